// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one cache coherent with its peers on a shared, arbitrated broadcast bus. It records a MESI state for every line of a small cache, indexed by line address. It takes read, write and evict requests from the local cache side. For each request it decides whether a bus transaction is needed. When one is, it raises a bus request and acts only once the arbiter grants it the bus, so the bus order is the order in which writes to a line take effect.

The controller also watches every transaction that other controllers place on the bus. It answers a read with a shared indication, and with a data-supply flag when it holds the line dirty. It downgrades or invalidates its own copy as the transaction requires. Data storage, replacement choice and deeper hierarchy levels live outside the block.

A system uses one instance per cache. The bus model ORs the snoop-shared outputs of the other instances into each requester's `busSharedIn`.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `lookupState`, and `busReq`, `busValid` and `reqDone` are low. State encoding: Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A request that needs no bus transaction completes with `reqDone` high in the cycle after it is accepted, and `busReq` stays low. The requests concerned are: a read of a Shared, Exclusive or Modified line; a write of an Exclusive or Modified line, which leaves it Modified; an evict of an Invalid, Shared or Exclusive line, which leaves it Invalid. Request codes: read=0, write=1, evict=2.
- R3: A read of an Invalid line raises `busReq`. In the grant cycle it drives `busCmd`=1 (read) with the line address. The line becomes Exclusive if `busSharedIn` is low in that cycle, and Shared otherwise.
- R4: A write to a Shared or Invalid line drives `busCmd`=2 (ownership request) in the grant cycle and leaves the line Modified.
- R5: An evict of a Modified line drives `busCmd`=3 (write-back) in the grant cycle and leaves the line Invalid. If the line is no longer Modified at grant, no transaction is driven and the line still ends Invalid.
- R6: `busValid` is high only in a cycle where both `busReq` and `busGnt` are high. `reqDone` follows in the next cycle and lasts for exactly one cycle.
- R7: A snooped read (`snpCmd`=1) that hits a valid line raises `snpShared` in the same cycle. A hit on a Modified line also raises `snpFlush`. An Exclusive or Modified line then becomes Shared.
- R8: A snooped ownership request (`snpCmd`=2) leaves the line Invalid. It raises `snpFlush` when the line was Modified, and leaves it low otherwise.
- R9: A snooped write-back (`snpCmd`=3), and any snoop of an Invalid line, changes no state and raises neither `snpShared` nor `snpFlush`.
- R10: If a local request waits in idle while a snoop targets the same line in the same cycle, the snoop is applied first. The request is then decided one cycle later on the updated state. A snoop to a different line does not delay the request.
- R11: The bus command is chosen at grant time from the line's state at that moment, so snoops that arrive while the request waits for the bus are taken into account.
- R12: `lookupState` shows the current state of the line at `lookupAddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Local request present; held until `reqDone` |
| reqOp | input | 2 | Request code: 0 read, 1 write, 2 evict |
| reqAddr | input | ADDR_W | Line address of the local request |
| reqDone | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Request for the shared bus |
| busGnt | input | 1 | Grant from the bus arbiter |
| busSharedIn | input | 1 | OR of the peers' shared replies, sampled in the grant cycle |
| busValid | output | 1 | This controller drives a transaction this cycle |
| busCmd | output | 2 | Transaction code: 1 read, 2 ownership, 3 write-back |
| busAddr | output | ADDR_W | Line address of the transaction |
| snpValid | input | 1 | A peer transaction is on the bus |
| snpCmd | input | 2 | Peer transaction code, same encoding as `busCmd` |
| snpAddr | input | ADDR_W | Peer transaction line address |
| snpShared | output | 1 | This cache holds a valid copy of the snooped line |
| snpFlush | output | 1 | This cache supplies dirty data and writes it back |
| lookupAddr | input | ADDR_W | Line to report on `lookupState` |
| lookupState | output | 2 | State of that line |

## Verification
A local request and a peer snoop can reach the same line in the same cycle. In one case the line is Exclusive, the local write is a silent hit, and the snoop is a read. The bench drives both in the same cycle, both in a directed case and in random traffic where the snoop address sometimes equals the request address. It expects the snoop to win: `snpShared` rises at once, the line drops to Shared, and one cycle later the write shows up as a bus request that issues an ownership command. A snoop to a different line in that cycle must not delay the request. The same ordering question arises while a request waits for the grant, where the bench injects snoops and computes the grant-time command from its updated model.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_READ = 2'd1,
    BC_OWN  = 2'd2,
    BC_WB   = 2'd3
  } busCmd_t;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_EVICT = 2'd2;

  // strobe from the sequencer into the state array
  typedef struct packed {
    logic       localWr;
    lineState_t localNext;
  } ctlStrobe_t;

endpackage

// File: rtl/mesi_line_state.sv
module mesi_line_state
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  output lineState_t        reqState,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic [1:0]        lookupState
);

  localparam int NLINES = 1 << ADDR_W;

  lineState_t lineQ [NLINES];
  lineState_t snpCur;
  lineState_t snpNext;
  logic       snpCmdRead;
  logic       snpCmdOwn;

  assign reqState    = lineQ[reqAddr];
  assign lookupState = lineQ[lookupAddr];
  assign snpCur      = lineQ[snpAddr];
  assign snpCmdRead  = (snpCmd == BC_READ);
  assign snpCmdOwn   = (snpCmd == BC_OWN);

  always_comb begin
    snpNext = snpCur;
    if (snpCmdRead && snpCur != LS_I) snpNext = LS_S;
    else if (snpCmdOwn)               snpNext = LS_I;
  end

  assign snpShared = snpValid && snpCmdRead && (snpCur != LS_I);
  assign snpFlush  = snpValid && (snpCmdRead || snpCmdOwn) && (snpCur == LS_M);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NLINES; i++) begin
      if (!rstN)
        lineQ[i] <= LS_I;
      else if (strobe.localWr && reqAddr == ADDR_W'(i))
        lineQ[i] <= strobe.localNext;
      else if (snpValid && snpAddr == ADDR_W'(i))
        lineQ[i] <= snpNext;
    end
  end

  // ---------------- assertions ----------------
  logic [ADDR_W-1:0] lastSnpAddr;
  always_ff @(posedge clk) lastSnpAddr <= snpAddr;

  // R8: a peer ownership request leaves our copy invalid
  a_r8_own_invalidates: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmdOwn) |=> (lineQ[lastSnpAddr] == LS_I));

  // R7: a shared reply means the line is Shared afterwards
  a_r7_read_leaves_shared: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmdRead && snpShared) |=> (lineQ[lastSnpAddr] == LS_S));

  // R10: a local update never lands on the line being snooped
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.localWr && snpValid && snpAddr == reqAddr));

endmodule

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  lineState_t        reqState,
  output logic              reqDone,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              busReq,
  input  logic              busGnt,
  input  logic              busSharedIn,
  output logic              busValid,
  output logic [1:0]        busCmd,
  output ctlStrobe_t        strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} seqState_t;

  seqState_t st, stNext;
  busCmd_t   cmd;
  logic      collide;
  logic      needBus;
  lineState_t hitNext;

  assign collide = snpValid && (snpAddr == reqAddr);

  always_comb begin
    unique case (reqOp)
      OP_WRITE: needBus = (reqState == LS_I) || (reqState == LS_S);
      OP_EVICT: needBus = (reqState == LS_M);
      default:  needBus = (reqState == LS_I);
    endcase
    unique case (reqOp)
      OP_WRITE: hitNext = LS_M;
      OP_EVICT: hitNext = LS_I;
      default:  hitNext = reqState;
    endcase
  end

  always_comb begin
    cmd = BC_NONE;
    unique case (reqOp)
      OP_WRITE: if (reqState == LS_I || reqState == LS_S) cmd = BC_OWN;
      OP_EVICT: if (reqState == LS_M) cmd = BC_WB;
      default:  if (reqState == LS_I) cmd = BC_READ;
    endcase
  end

  always_comb begin
    stNext           = st;
    strobe           = '0;
    strobe.localNext = LS_I;
    busReq           = 1'b0;
    busValid         = 1'b0;
    busCmd           = BC_NONE;
    reqDone          = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (reqValid && !collide) begin
          if (needBus) begin
            stNext = ST_WAIT;
          end else begin
            strobe.localWr   = 1'b1;
            strobe.localNext = hitNext;
            stNext           = ST_DONE;
          end
        end
      end
      ST_WAIT: begin
        busReq = 1'b1;
        if (busGnt) begin
          busCmd         = cmd;
          busValid       = (cmd != BC_NONE);
          strobe.localWr = 1'b1;
          unique case (cmd)
            BC_READ: strobe.localNext = busSharedIn ? LS_S : LS_E;
            BC_OWN:  strobe.localNext = LS_M;
            BC_WB:   strobe.localNext = LS_I;
            default: strobe.localNext = (reqOp == OP_EVICT) ? LS_I : reqState;
          endcase
          stNext = ST_DONE;
        end
      end
      default: begin
        reqDone = 1'b1;
        stNext  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  // ---------------- assertions ----------------
  a_r6_valid_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busGnt && busReq));

  a_r6_done_after_tx: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> reqDone);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  // R6: the bus request drops once the grant has been used
  a_r6_release_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt) |=> !busReq);

  // R2: a completion without a preceding grant never saw busReq in between
  a_r2_silent_no_req: assert property (@(posedge clk) disable iff (!rstN)
    (reqDone && !$past(busGnt)) |-> !$past(busReq));

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqDone,
  output logic              busReq,
  input  logic              busGnt,
  input  logic              busSharedIn,
  output logic              busValid,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic [1:0]        lookupState
);

  ctlStrobe_t strobe;
  lineState_t reqState;

  assign busAddr = reqAddr;

  mesi_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqState(reqState), .reqDone(reqDone),
    .snpValid(snpValid), .snpAddr(snpAddr),
    .busReq(busReq), .busGnt(busGnt), .busSharedIn(busSharedIn),
    .busValid(busValid), .busCmd(busCmd), .strobe(strobe)
  );

  mesi_line_state #(.ADDR_W(ADDR_W)) u_lines (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .reqAddr(reqAddr), .reqState(reqState),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpShared(snpShared), .snpFlush(snpFlush),
    .lookupAddr(lookupAddr), .lookupState(lookupState)
  );

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb;

  localparam int AW = 3;
  localparam int NL = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, busGnt = 0, busSharedIn = 0, snpValid = 0;
  logic [1:0] reqOp = 0, snpCmd = 0;
  logic [AW-1:0] reqAddr = 0, snpAddr = 0, lookupAddr = 0;
  logic reqDone, busReq, busValid, snpShared, snpFlush;
  logic [1:0] busCmd, lookupState;
  logic [AW-1:0] busAddr;

  int vectors = 0;
  int fails = 0;
  logic [1:0] refSt [NL];

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqDone(reqDone),
    .busReq(busReq), .busGnt(busGnt), .busSharedIn(busSharedIn),
    .busValid(busValid), .busCmd(busCmd), .busAddr(busAddr),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpShared(snpShared), .snpFlush(snpFlush),
    .lookupAddr(lookupAddr), .lookupState(lookupState)
  );

  // ---------- expected-value functions (I=0 S=1 E=2 M=3) ----------
  function automatic bit fNeedBus(logic [1:0] op, logic [1:0] s);
    if (op == 2'd1) return (s == 2'd0 || s == 2'd1);
    if (op == 2'd2) return (s == 2'd3);
    return (s == 2'd0);
  endfunction

  function automatic logic [1:0] fHitNext(logic [1:0] op, logic [1:0] s);
    if (op == 2'd1) return 2'd3;
    if (op == 2'd2) return 2'd0;
    return s;
  endfunction

  function automatic logic [1:0] fGrantCmd(logic [1:0] op, logic [1:0] s);
    if (op == 2'd1) return (s == 2'd0 || s == 2'd1) ? 2'd2 : 2'd0;
    if (op == 2'd2) return (s == 2'd3) ? 2'd3 : 2'd0;
    return (s == 2'd0) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [1:0] fGrantNext(logic [1:0] op, logic [1:0] s, logic shr);
    logic [1:0] c;
    c = fGrantCmd(op, s);
    if (c == 2'd1) return shr ? 2'd1 : 2'd2;
    if (c == 2'd2) return 2'd3;
    if (c == 2'd3) return 2'd0;
    return (op == 2'd2) ? 2'd0 : s;
  endfunction

  function automatic logic [1:0] fSnpNext(logic [1:0] c, logic [1:0] s);
    if (c == 2'd1) return (s == 2'd0) ? 2'd0 : 2'd1;
    if (c == 2'd2) return 2'd0;
    return s;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive a snoop at the current negedge, check replies (R7 R8 R9)
  task automatic snoopNow(logic [1:0] c, logic [AW-1:0] a);
    logic [1:0] s;
    s = refSt[a];
    snpValid = 1; snpCmd = c; snpAddr = a;
    #1;
    chk(snpShared == (c == 2'd1 && s != 2'd0), "R7/R9 snpShared", snpShared,
        (c == 2'd1 && s != 2'd0));
    chk(snpFlush == ((c == 2'd1 || c == 2'd2) && s == 2'd3), "R7/R8 snpFlush", snpFlush,
        ((c == 2'd1 || c == 2'd2) && s == 2'd3));
  endtask

  task automatic checkLine(logic [AW-1:0] a, string req);
    lookupAddr = a;
    #1;
    chk(lookupState == refSt[a], req, lookupState, refSt[a]);
  endtask

  task automatic snoopOp(logic [1:0] c, logic [AW-1:0] a);
    @(negedge clk);
    snoopNow(c, a);
    @(negedge clk);
    snpValid = 0;
    refSt[a] = fSnpNext(c, refSt[a]);
    checkLine(a, "R8/R9 state after snoop");
  endtask

  // sMode: 0 none, 1 snoop in the accept cycle, 2 snoop while waiting for the bus
  task automatic localOp(logic [1:0] op, logic [AW-1:0] a, int sMode,
                         logic [1:0] sc, logic [AW-1:0] sa, logic shr, int gd);
    bit need;
    logic [1:0] ec;
    @(negedge clk);
    reqValid = 1; reqOp = op; reqAddr = a;
    if (sMode == 1) begin
      snoopNow(sc, sa);
      @(negedge clk);
      snpValid = 0;
      refSt[sa] = fSnpNext(sc, refSt[sa]);
      if (sa == a) @(negedge clk);   // R10: request decided one cycle later
    end else begin
      @(negedge clk);
    end
    need = fNeedBus(op, refSt[a]);
    #1;
    chk(busReq == need, "R2/R3/R10 busReq", busReq, need);
    chk(reqDone == !need, "R2 reqDone", reqDone, !need);
    if (!need) begin
      reqValid = 0;
      refSt[a] = fHitNext(op, refSt[a]);
      checkLine(a, "R2 state after hit");
    end else begin
      if (sMode == 2) begin
        snoopNow(sc, sa);
        @(negedge clk);
        snpValid = 0;
        refSt[sa] = fSnpNext(sc, refSt[sa]);
      end
      for (int k = 0; k < gd; k++) begin
        @(negedge clk);
        #1;
        chk(busReq == 1'b1 && busValid == 1'b0, "R6 waiting", busValid, 0);
      end
      if (gd == 0 && sMode != 2) begin end
      busGnt = 1; busSharedIn = shr;
      ec = fGrantCmd(op, refSt[a]);
      #1;
      chk(busValid == (ec != 2'd0), "R5/R6/R11 busValid", busValid, (ec != 2'd0));
      if (ec != 2'd0) begin
        chk(busCmd == ec, "R3/R4/R5/R11 busCmd", busCmd, ec);
        chk(busAddr == a, "R3 busAddr", busAddr, a);
      end
      @(negedge clk);
      busGnt = 0; busSharedIn = 0;
      refSt[a] = fGrantNext(op, refSt[a], shr);
      #1;
      chk(reqDone == 1'b1, "R6 reqDone after grant", reqDone, 1);
      reqValid = 0;
      checkLine(a, "R3/R4/R5 state after grant");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NL; i++) refSt[i] = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk(busReq == 0 && busValid == 0 && reqDone == 0, "R1 idle outputs", busReq, 0);
    for (int i = 0; i < NL; i++) checkLine(AW'(i), "R1/R12 reset line");

    // directed
    localOp(2'd0, 3'd1, 0, 2'd0, 3'd0, 1'b0, 1);   // R3 read miss -> E
    localOp(2'd1, 3'd1, 0, 2'd0, 3'd0, 1'b0, 0);   // R2 silent E->M
    snoopOp(2'd1, 3'd1);                          // R7 flush, -> S
    localOp(2'd1, 3'd1, 0, 2'd0, 3'd0, 1'b0, 2);   // R4 S -> ownership -> M
    snoopOp(2'd2, 3'd1);                          // R8 flush, -> I
    localOp(2'd0, 3'd2, 0, 2'd0, 3'd0, 1'b1, 0);   // R3 shared -> S
    localOp(2'd2, 3'd2, 0, 2'd0, 3'd0, 1'b0, 0);   // R2 silent evict
    localOp(2'd0, 3'd3, 0, 2'd0, 3'd0, 1'b0, 0);   // -> E
    localOp(2'd1, 3'd3, 1, 2'd1, 3'd3, 1'b0, 1);   // R10 collision
    localOp(2'd2, 3'd3, 2, 2'd1, 3'd3, 1'b0, 0);   // R5/R11 M lost while waiting
    localOp(2'd1, 3'd4, 0, 2'd0, 3'd0, 1'b0, 0);   // R4 I -> M
    localOp(2'd2, 3'd4, 0, 2'd0, 3'd0, 1'b0, 1);   // R5 write-back
    snoopOp(2'd3, 3'd5);                          // R9 peer write-back
    snoopOp(2'd1, 3'd6);                          // R9 snoop of Invalid line
    localOp(2'd0, 3'd5, 1, 2'd1, 3'd6, 1'b0, 0);   // R10 other-line snoop, no delay

    // constrained random
    for (int it = 0; it < 500; it++) begin
      logic [AW-1:0] a, sa;
      logic [1:0] op, sc;
      int mode;
      a  = AW'($urandom_range(0, NL - 1));
      sa = ($urandom_range(0, 2) == 0) ? a : AW'($urandom_range(0, NL - 1));
      sc = 2'($urandom_range(1, 2));
      op = 2'($urandom_range(0, 2));
      mode = $urandom_range(0, 2);
      if ($urandom_range(0, 3) == 0) begin
        if (refSt[sa] == 2'd0 && $urandom_range(0, 1) == 1) sc = 2'd3;
        snoopOp(sc, sa);
      end else begin
        localOp(op, a, mode, sc, sa, 1'($urandom_range(0, 1)), $urandom_range(0, 3));
      end
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule